// File: doc/BRIEF.md
# Paragraph-Aligned Service Header Scanner

This block searches a byte-addressed ROM window for a service directory header. It reads the window through a byte-wide memory port. Only locations on 16-byte boundaries are candidates, and they are tried in ascending address order. A candidate is a header when its first four bytes hold a fixed 32-bit signature and its checksum is valid. The checksummed region starts at the candidate, and its length comes from a length field inside the header, counted in 16-byte paragraphs.

The search stops at the first header that passes both tests. The block then reports the header address and splits the 32-bit entry point stored in the header into a 4 KB page base and an offset within that page. If the window holds no valid header, the block ends with a not-found result. Software or a boot sequencer pulses `start` and waits for the one-cycle `done` pulse.

Top module: `para_sig_scanner`

## Requirements
- R1: Candidates are at `BASE_ADDR + 16*k` and are tried in increasing k. Every read address lies between the current candidate and that candidate plus 255.
- R2: A candidate is rejected at the first of bytes 0..3 that differs from the little-endian signature `SIGNATURE`. With the default `0x5F32335F`, the bytes are 0x5F, 0x33, 0x32, 0x5F. No further byte of that candidate is read.
- R3: When the signature matches, byte 9 is the paragraph count. The size is that count times 16, kept to 8 bits. The bytes from offset 0 to size-1 must add to 0 modulo 256. If they do not, the scan moves on to the next 16-byte boundary.
- R4: A size of zero is rejected without a checksum read. This happens when the low nibble of byte 9 is 0, for example a count of 0 or 16.
- R5: The first candidate that passes ends the scan. `done` pulses for one cycle with `found`=1 and `hdr_addr` set to the candidate address. `busy` is low in that cycle.
- R6: On success, `page_base` holds the entry point with bits 11:0 cleared and `page_off` holds bits 11:0 of the entry point. The entry point is bytes 4..7, little-endian.
- R7: The last candidate is the highest boundary whose offset from `BASE_ADDR` is below `WINDOW`. If no candidate passes, `done` pulses with `found`, `hdr_addr`, `page_base` and `page_off` all 0.
- R8: At most one read is outstanding. `rd_req` is a one-cycle pulse, and no new request is made before `rd_valid` returns the previous byte.
- R9: `start` while `busy` is ignored: the scan's reads and result are unchanged.
- R10: After reset `busy`, `done`, `found` and `rd_req` are 0. No read is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a scan when idle |
| busy | output | 1 | scan in progress |
| done | output | 1 | one-cycle completion pulse |
| found | output | 1 | valid header located |
| hdr_addr | output | AW | address of the header |
| page_base | output | 32 | entry point, page aligned |
| page_off | output | 32 | entry point offset within page |
| rd_req | output | 1 | byte read request pulse |
| rd_addr | output | AW | byte read address |
| rd_valid | input | 1 | read data strobe |
| rd_data | input | 8 | returned byte |

## Verification
The assertions assume the memory never raises `rd_valid` unless a read is outstanding, and never in the same cycle as the request. They also assume it returns exactly one byte for each request. The bench responder follows this. It samples the request between clock edges and answers after one to three further cycles, the delay varying from read to read. It drops the strobe after one cycle, so each request gets exactly one response.

// File: rtl/para_sig_scanner.sv
module para_sig_scanner #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 32'h000F_0000,
  parameter logic [AW-1:0] WINDOW = 32'h0000_FFFF,
  parameter logic [31:0] SIGNATURE = 32'h5F32335F,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [AW-1:0] hdr_addr,
  output logic [31:0]   page_base,
  output logic [31:0]   page_off,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data
);
  localparam logic [31:0] OFF_MASK = (32'h1 << PAGE_BITS) - 32'h1;
  localparam logic [AW-1:0] PARA = AW'(16);
  localparam logic [7:0] LEN_POS = 8'd9;

  typedef enum logic [1:0] {ST_IDLE, ST_SIG, ST_LEN, ST_SUM} st_t;

  st_t state;
  logic [AW-1:0] cand;
  logic [7:0] off, sum, size;
  logic [31:0] entry, entry_nx;
  logic pend, adv, win;

  wire take = pend && rd_valid;
  wire [7:0] sum_nx = sum + rd_data;
  wire [7:0] sig_byte = SIGNATURE[off[1:0]*8 +: 8];
  wire [AW-1:0] next_rel = cand - BASE_ADDR + PARA;
  wire last_cand = next_rel >= WINDOW;

  assign busy = state != ST_IDLE;
  assign rd_req = busy && !pend;
  assign rd_addr = cand + AW'(off);

  always_comb begin
    entry_nx = entry;
    if (state == ST_SUM && off[7:2] == 6'd1) entry_nx[off[1:0]*8 +: 8] = rd_data;
  end

  always_comb begin
    adv = 1'b0;
    win = 1'b0;
    case (state)
      ST_SIG: adv = take && rd_data != sig_byte;
      ST_LEN: adv = take && rd_data[3:0] == 4'h0;
      ST_SUM: if (take && off == size - 8'd1) begin
        win = sum_nx == 8'h00;
        adv = sum_nx != 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cand <= '0;
      off <= '0;
      sum <= '0;
      size <= '0;
      entry <= '0;
      pend <= 1'b0;
      done <= 1'b0;
      found <= 1'b0;
      hdr_addr <= '0;
      page_base <= '0;
      page_off <= '0;
    end else begin
      done <= 1'b0;
      if (rd_req) pend <= 1'b1;
      else if (take) pend <= 1'b0;
      if (win) begin
        state <= ST_IDLE;
        done <= 1'b1;
        found <= 1'b1;
        hdr_addr <= cand;
        page_base <= entry_nx & ~OFF_MASK;
        page_off <= entry_nx & OFF_MASK;
      end else if (adv) begin
        if (last_cand) begin
          state <= ST_IDLE;
          done <= 1'b1;
        end else begin
          cand <= cand + PARA;
          off <= '0;
          sum <= '0;
          state <= ST_SIG;
        end
      end else begin
        case (state)
          ST_IDLE: if (start) begin
            cand <= BASE_ADDR;
            off <= '0;
            sum <= '0;
            entry <= '0;
            found <= 1'b0;
            hdr_addr <= '0;
            page_base <= '0;
            page_off <= '0;
            state <= ST_SIG;
          end
          ST_SIG: if (take) begin
            sum <= sum_nx;
            if (off == 8'd3) begin
              off <= LEN_POS;
              state <= ST_LEN;
            end else off <= off + 8'd1;
          end
          ST_LEN: if (take) begin
            size <= {rd_data[3:0], 4'h0};
            off <= 8'd4;
            state <= ST_SUM;
          end
          ST_SUM: if (take) begin
            sum <= sum_nx;
            entry <= entry_nx;
            off <= off + 8'd1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_REQ_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R8
  AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> rd_addr >= BASE_ADDR); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R5
  AST_PAGE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    done && found |-> page_base[PAGE_BITS-1:0] == '0 && (page_off & ~OFF_MASK) == '0); // R6
  AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && !found |-> hdr_addr == '0 && page_base == '0 && page_off == '0); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_req); // R10
endmodule

// File: tb/para_sig_scanner_test.sv
module para_sig_scanner_test;
  localparam logic [31:0] BASE = 32'h000F_0000;
  localparam logic [31:0] WIN = 32'h0000_03FF;
  localparam int MEMSZ = 1280;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, found, rd_req, rd_valid;
  logic [31:0] hdr_addr, page_base, page_off, rd_addr;
  logic [7:0] rd_data;
  logic [7:0] mem [0:MEMSZ-1];
  int checks = 0, errors = 0, nreq = 0;

  always #10 clk = ~clk;

  para_sig_scanner #(.AW(32), .BASE_ADDR(BASE), .WINDOW(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .found(found),
    .hdr_addr(hdr_addr), .page_base(page_base), .page_off(page_off),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  initial begin
    rd_valid = 1'b0;
    rd_data = 8'h00;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        automatic int idx = int'(rd_addr - BASE);
        automatic int lat = 1 + (nreq % 3);
        nreq++;
        repeat (lat) @(negedge clk);
        rd_data = (idx >= 0 && idx < MEMSZ) ? mem[idx] : 8'h00;
        rd_valid = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i] = 8'((i * 37 + seed * 11 + 3) & 255);
      if (mem[i] == 8'h5F) mem[i] = 8'h60;
    end
  endtask

  task automatic place(input int rel, input logic [31:0] ep, input logic [7:0] len, input bit bad);
    automatic logic [7:0] s = 8'h00;
    automatic int size = (len * 16) & 255;
    for (int i = 0; i < 16; i++) mem[rel + i] = 8'h00;
    mem[rel] = 8'h5F; mem[rel + 1] = 8'h33; mem[rel + 2] = 8'h32; mem[rel + 3] = 8'h5F;
    for (int i = 0; i < 4; i++) mem[rel + 4 + i] = ep[i*8 +: 8];
    mem[rel + 8] = 8'h01;
    mem[rel + 9] = len;
    for (int i = 0; i < size; i++) s = s + mem[rel + i];
    mem[rel + 10] = 8'h00 - s + (bad ? 8'h01 : 8'h00);
  endtask

  task automatic model(output bit f, output logic [31:0] h, output logic [31:0] e, output int n);
    f = 1'b0; h = 0; e = 0; n = 0;
    for (int c = 0; c < int'(WIN) && !f; c += 16) begin
      automatic bit ok = 1'b1;
      automatic logic [7:0] sig [4] = '{8'h5F, 8'h33, 8'h32, 8'h5F};
      for (int i = 0; i < 4 && ok; i++) begin
        n++;
        if (mem[c + i] != sig[i]) ok = 1'b0;
      end
      if (ok) begin
        automatic int size = (mem[c + 9] * 16) & 255;
        automatic logic [7:0] s = 8'h00;
        n++;
        if (size != 0) begin
          n += size - 4;
          for (int i = 0; i < size; i++) s = s + mem[c + i];
          if (s == 8'h00) begin
            f = 1'b1;
            h = BASE + c;
            e = {mem[c + 7], mem[c + 6], mem[c + 5], mem[c + 4]};
          end
        end
      end
    end
  endtask

  task automatic run(input string tag, input bit poke);
    bit ef; logic [31:0] eh, ee; int en, t;
    model(ef, eh, ee, en);
    @(negedge clk);
    nreq = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
      start = (poke && (t == 5 || t == 40));
    end
    start = 1'b0;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 %s watchdog actual=running expected=done", tag);
      return;
    end
    chk({tag, " R5 found"}, found, ef);
    chk({tag, " R5 hdr_addr"}, hdr_addr, ef ? eh : 32'h0);
    chk({tag, " R6 page_base"}, page_base, ef ? (ee & 32'hFFFF_F000) : 32'h0);
    chk({tag, " R6 page_off"}, page_off, ef ? (ee & 32'h0000_0FFF) : 32'h0);
    chk({tag, " R1 R3 read count"}, nreq, en);
    chk({tag, " R5 busy low at done"}, busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 0); chk("R10 done", done, 0);
    chk("R10 found", found, 0); chk("R10 rd_req", rd_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle no read", nreq, 0);

    fill(1); run("R7 empty", 0);
    fill(2); place(32'h120, 32'hC00F_7A34, 8'd1, 0); run("R2 single", 0);
    fill(3); place(32'h40, 32'h0001_2345, 8'd1, 1); place(32'h200, 32'hFFFF_FFFF, 8'd2, 0); run("R3 bad sum", 0);
    fill(4); place(32'h60, 32'h1, 8'd0, 0); place(32'h80, 32'h2, 8'd16, 0); run("R4 zero size", 0);
    fill(4); place(32'h60, 32'h1, 8'd0, 0); place(32'h80, 32'h2, 8'd16, 0); place(32'h300, 32'h0000_1000, 8'd3, 0); run("R4 then hit", 0);
    fill(5); place(32'h90, 32'h0ABC_DFFF, 8'd1, 0); place(32'hA0, 32'h5555_5555, 8'd1, 0); run("R5 first wins", 0);
    fill(6); place(32'h3F0, 32'h8765_4321, 8'd15, 0); run("R7 last cand", 0);
    fill(7); place(32'h105, 32'h1234_5678, 8'd1, 0); run("R1 unaligned", 0);
    fill(8); place(32'h2A0, 32'h0F0F_0F0F, 8'd4, 0); run("R9 start busy", 1);
    fill(9); mem[32'h50] = 8'h5F; mem[32'h51] = 8'h33; mem[32'h52] = 8'h00; run("R2 partial sig", 0);

    for (int k = 0; k < 64; k++) begin
      fill(k + 10);
      place(k * 16, 32'h1000_0000 + k * 32'h0001_0137, 8'(1 + (k % 15)), 0);
      if (k > 0) place((k - 1) * 16, 32'hDEAD_0000, 8'd1, (k % 2) == 1);
      run("R3 sweep", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule